// File: doc/BRIEF.md
# Cartridge Window Decoder with Vector Override

This block sits between the host's address and data bus and a flash read sequencer. It watches every host read and decides whether the cartridge should drive the data bus. It has two ways to serve a read. The first is the 8 KB game window at $8000–$9FFF, which returns bytes from the currently selected flash bank. The second is a fixed table of eight interrupt-vector bytes at $FFF8–$FFFF. That table sends the NMI and IRQ vectors into zero page. It applies whatever state the host's own memory banking is in.

The block holds three control bits, loaded through a plain write strobe: vector override, window release and bit-bang.

- A window read becomes a single flash request. The request leaves on a valid/ready channel. Valid holds steady, with a stable address, until the sequencer takes it. This lets the sequencer apply back-pressure for as long as it likes.
- The sequencer answers with one byte on a response strobe. The block always accepts that byte at once, so the response channel has no ready signal.
- The I/O page select is decoded at all times, whatever the control bits say.
- The active-low EXROM line tells the host whether the window is mapped.

Top module: `cart_window`

## Requirements
- R1: A host read that starts (bus_rd rises) while the block is idle, with an address in $8000–$9FFF, window release 0 and bit-bang 0, produces exactly one request. It leaves on req_valid in the cycle after the start, with req_addr = {bank_sel, bus_addr[12:0]}. req_valid and req_addr stay unchanged until req_ready is seen high.
- R2: When the response strobe fl_valid arrives while that read is still active, bus_oe goes high with bus_dout = fl_data from the next cycle. Both hold until the cycle after bus_rd falls. bus_dout is 0 whenever bus_oe is low.
- R3: With window release (ctl_wdata[1]) set, a window-address read issues no request and drives nothing.
- R4: With bit-bang (ctl_wdata[2]) set, window reads issue no request. A window byte already being driven is withdrawn in the cycle after the control write is sampled.
- R5: exrom_n is low exactly when window release and bit-bang are both 0. It follows a control write in the next cycle.
- R6: With vector override (ctl_wdata[0]) set, a read starting at $FFF8–$FFFF drives, from the next cycle, the byte selected by address bits 2:0 from the list 08,00,08,00,0C,80,0C,00. This makes the NMI vector $0008, the reset vector $800C and the IRQ vector $000C. Window release and bit-bang have no effect on it.
- R7: With vector override clear, reads at $FFF8–$FFFF are not driven.
- R8: io_sel is high in the same cycle whenever bus_rd is high and bus_addr[15:8] = $DE, independent of every control bit.
- R9: After reset, release and bit-bang are 0, and vector override equals the VEC_RST parameter. bus_oe, req_valid and io_sel are low, and exrom_n is low.
- R10: If bus_rd falls before the flash byte arrives, the byte is consumed and dropped. bus_oe stays low, and the block returns to idle.
- R11: Reads outside both regions are never driven, and neither is a read that starts while a flash fetch is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Host address |
| bus_rd | input | 1 | Host read strobe, high for the whole access |
| ctl_we | input | 1 | Control bit write strobe |
| ctl_wdata | input | 3 | {bit-bang, window release, vector override} |
| bank_sel | input | BANK_W | Current flash bank number |
| req_valid | output | 1 | Flash byte request valid |
| req_ready | input | 1 | Sequencer accepts the request |
| req_addr | output | BANK_W+13 | Flash byte address |
| fl_valid | input | 1 | Flash byte returned |
| fl_data | input | 8 | Returned flash byte |
| bus_oe | output | 1 | Cartridge drives the data bus |
| bus_dout | output | 8 | Byte driven to the host |
| exrom_n | output | 1 | Active-low window mapping line |
| io_sel | output | 1 | I/O page access select |

## Verification
A wrong fetch state shows at the ports within a cycle or two. It appears as a req_valid that drops before req_ready, a second request for one read, or bus_oe rising for an abandoned or unmapped read. A stale control bit shows on exrom_n in the cycle after the write, and also as a window byte that is not withdrawn when bit-bang is entered. A wrong vector table entry shows up as a wrong byte on the first cycle of a vector read. The bench compares every output against its own model on every clock, so any such divergence is caught in the cycle it first appears.

// File: rtl/cw_pkg.sv
package cw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_REQ   = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DRIVE = 2'd3
  } cw_state_t;

  typedef enum logic {
    SRC_VEC = 1'b0,
    SRC_WIN = 1'b1
  } cw_src_t;

  typedef struct packed {
    logic bitbang;
    logic release_win;
    logic vec_on;
  } cw_ctl_t;

  // Byte of the override table at offset idx (0 = $xxF8).
  // Slots 0/1 repeat the NMI target, 2/3 NMI, 4/5 reset, 6/7 IRQ.
  function automatic logic [7:0] vec_byte(input logic [2:0] idx,
                                          input logic [15:0] nmi_t,
                                          input logic [15:0] rst_t,
                                          input logic [15:0] irq_t);
    logic [15:0] word;
    case (idx[2:1])
      2'd0:    word = nmi_t;
      2'd1:    word = nmi_t;
      2'd2:    word = rst_t;
      default: word = irq_t;
    endcase
    return idx[0] ? word[15:8] : word[7:0];
  endfunction

endpackage

// File: rtl/cw_ctrl.sv
module cw_ctrl
  import cw_pkg::*;
#(
  parameter bit VEC_RST = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] wdata,
  output cw_ctl_t    ctl
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl.bitbang     <= 1'b0;
      ctl.release_win <= 1'b0;
      ctl.vec_on      <= VEC_RST;
    end else if (we) begin
      ctl.bitbang     <= wdata[2];
      ctl.release_win <= wdata[1];
      ctl.vec_on      <= wdata[0];
    end
  end

endmodule

// File: rtl/cw_decode.sv
module cw_decode
  import cw_pkg::*;
#(
  parameter logic [2:0]  WIN_TAG = 3'b100,
  parameter logic [7:0]  IO_PAGE = 8'hDE,
  parameter logic [15:0] NMI_T   = 16'h0008,
  parameter logic [15:0] RST_T   = 16'h800C,
  parameter logic [15:0] IRQ_T   = 16'h000C
) (
  input  logic [15:0] addr,
  input  logic        rd,
  input  cw_ctl_t     ctl,
  output logic        win_hit,
  output logic        vec_hit,
  output logic        io_hit,
  output logic [7:0]  vec_data
);

  localparam int VEC_N = 8;

  logic [7:0] vec_tab [VEC_N];

  for (genvar g = 0; g < VEC_N; g++) begin : g_vec
    assign vec_tab[g] = vec_byte(3'(g), NMI_T, RST_T, IRQ_T);
  end

  always_comb begin
    win_hit  = (addr[15:13] == WIN_TAG) && !ctl.release_win && !ctl.bitbang;
    vec_hit  = (addr[15:3] == 13'h1FFF) && ctl.vec_on;
    io_hit   = rd && (addr[15:8] == IO_PAGE);
    vec_data = vec_tab[addr[2:0]];
  end

endmodule

// File: rtl/cw_fetch.sv
module cw_fetch
  import cw_pkg::*;
#(
  parameter int FL_AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd,
  input  logic             win_hit,
  input  logic             vec_hit,
  input  logic [7:0]       vec_data,
  input  logic [FL_AW-1:0] fl_addr,
  input  logic             gate_off,
  output logic             rd_start,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [FL_AW-1:0] req_addr,
  input  logic             fl_valid,
  input  logic [7:0]       fl_data,
  output logic             oe,
  output logic [7:0]       dout
);

  cw_state_t  st;
  cw_src_t    src;
  logic       rd_q;
  logic       drop;
  logic [7:0] data_q;

  assign rd_start = rd && !rd_q && (st == ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      src      <= SRC_VEC;
      rd_q     <= 1'b0;
      drop     <= 1'b0;
      data_q   <= '0;
      req_addr <= '0;
    end else begin
      rd_q <= rd;
      unique case (st)
        ST_IDLE: begin
          if (rd_start && win_hit) begin
            st       <= ST_REQ;
            src      <= SRC_WIN;
            req_addr <= fl_addr;
            drop     <= 1'b0;
          end else if (rd_start && vec_hit) begin
            st     <= ST_DRIVE;
            src    <= SRC_VEC;
            data_q <= vec_data;
          end
        end
        ST_REQ: begin
          if (!rd) drop <= 1'b1;
          if (req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (!rd) drop <= 1'b1;
          if (fl_valid) begin
            if (drop || !rd) begin
              st <= ST_IDLE;
            end else begin
              st     <= ST_DRIVE;
              data_q <= fl_data;
            end
          end
        end
        ST_DRIVE: begin
          if (!rd) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_valid = (st == ST_REQ);
    oe        = (st == ST_DRIVE) && !((src == SRC_WIN) && gate_off);
    dout      = oe ? data_q : 8'h00;
  end

endmodule

// File: rtl/cart_window.sv
module cart_window
  import cw_pkg::*;
#(
  parameter int          BANK_W  = 11,
  parameter bit          VEC_RST = 1'b0,
  parameter logic [15:0] NMI_T   = 16'h0008,
  parameter logic [15:0] RST_T   = 16'h800C,
  parameter logic [15:0] IRQ_T   = 16'h000C,
  localparam int         FL_AW   = BANK_W + 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       bus_addr,
  input  logic              bus_rd,
  input  logic              ctl_we,
  input  logic [2:0]        ctl_wdata,
  input  logic [BANK_W-1:0] bank_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [FL_AW-1:0]  req_addr,
  input  logic              fl_valid,
  input  logic [7:0]        fl_data,
  output logic              bus_oe,
  output logic [7:0]        bus_dout,
  output logic              exrom_n,
  output logic              io_sel
);

  cw_ctl_t    ctl;
  logic       win_hit;
  logic       vec_hit;
  logic [7:0] vec_data;
  logic       rd_start;
  logic       gate_off;

  cw_ctrl #(.VEC_RST(VEC_RST)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (ctl_we),
    .wdata (ctl_wdata),
    .ctl   (ctl)
  );

  cw_decode #(.NMI_T(NMI_T), .RST_T(RST_T), .IRQ_T(IRQ_T)) u_decode (
    .addr     (bus_addr),
    .rd       (bus_rd),
    .ctl      (ctl),
    .win_hit  (win_hit),
    .vec_hit  (vec_hit),
    .io_hit   (io_sel),
    .vec_data (vec_data)
  );

  assign gate_off = ctl.release_win | ctl.bitbang;
  assign exrom_n  = gate_off;

  cw_fetch #(.FL_AW(FL_AW)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd        (bus_rd),
    .win_hit   (win_hit),
    .vec_hit   (vec_hit),
    .vec_data  (vec_data),
    .fl_addr   ({bank_sel, bus_addr[12:0]}),
    .gate_off  (gate_off),
    .rd_start  (rd_start),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .fl_valid  (fl_valid),
    .fl_data   (fl_data),
    .oe        (bus_oe),
    .dout      (bus_dout)
  );

endmodule

// File: rtl/cw_checker.sv
module cw_checker #(
  parameter int FL_AW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_rd,
  input logic             ctl_we,
  input logic [2:0]       ctl_wdata,
  input logic             req_valid,
  input logic             req_ready,
  input logic [FL_AW-1:0] req_addr,
  input logic             bus_oe,
  input logic             exrom_n,
  input logic             rd_start,
  input logic             vec_hit
);

  assert_req_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  assert_oe_needs_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> $past(bus_rd));

  assert_req_only_mapped_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(req_valid) |-> $past(!exrom_n));

  assert_exrom_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> exrom_n == $past(ctl_wdata[2] | ctl_wdata[1]));

  assert_vec_served_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_start && vec_hit |=> bus_oe);

endmodule

bind cart_window cw_checker #(.FL_AW(FL_AW)) u_cw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .ctl_we    (ctl_we),
  .ctl_wdata (ctl_wdata),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_addr  (req_addr),
  .bus_oe    (bus_oe),
  .exrom_n   (exrom_n),
  .rd_start  (rd_start),
  .vec_hit   (vec_hit)
);

// File: tb/test_cart_window.sv
module test_cart_window;

  localparam int BANK_W = 11;
  localparam int FL_AW  = BANK_W + 13;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [15:0]       bus_addr = '0;
  logic              bus_rd = 1'b0;
  logic              ctl_we = 1'b0;
  logic [2:0]        ctl_wdata = '0;
  logic [BANK_W-1:0] bank_sel = '0;
  logic              req_ready = 1'b0;
  logic              fl_valid = 1'b0;
  logic [7:0]        fl_data = '0;
  logic              req_valid, bus_oe, exrom_n, io_sel;
  logic [FL_AW-1:0]  req_addr;
  logic [7:0]        bus_dout;
  logic              vr_req_valid, vr_oe, vr_exrom_n, vr_io_sel;
  logic [FL_AW-1:0]  vr_req_addr;
  logic [7:0]        vr_dout;

  always #10 clk = ~clk;

  cart_window #(.BANK_W(BANK_W)) i_cart_window (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .bank_sel(bank_sel),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .fl_valid(fl_valid), .fl_data(fl_data), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .exrom_n(exrom_n), .io_sel(io_sel)
  );

  cart_window #(.BANK_W(BANK_W), .VEC_RST(1'b1)) i_cart_window_vr (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .ctl_we(1'b0), .ctl_wdata(3'b000), .bank_sel(bank_sel),
    .req_valid(vr_req_valid), .req_ready(1'b1), .req_addr(vr_req_addr),
    .fl_valid(1'b0), .fl_data(8'h00), .bus_oe(vr_oe),
    .bus_dout(vr_dout), .exrom_n(vr_exrom_n), .io_sel(vr_io_sel)
  );

  int checks = 0;
  int errors = 0;
  string cur_tag = "R2";

  // ---------------- reference model ----------------
  int               m_st = 0;      // 0 idle, 1 request, 2 wait, 3 drive
  bit               m_win = 0;
  bit               m_drop = 0;
  bit               m_rdq = 0;
  bit               m_bb = 0, m_ex = 0, m_vec = 0;
  logic [7:0]       m_data = '0;
  logic [FL_AW-1:0] m_req_addr = '0;
  int               pend = 0;
  int               cur_lat = 1;
  logic [FL_AW-1:0] pend_addr = '0;
  logic [7:0]       rdy_pat = 8'hFF;
  int               n_req = 0;

  function automatic logic [7:0] flash_byte(input logic [FL_AW-1:0] a);
    return a[7:0] ^ a[20:13] ^ {a[12:8], 3'b101};
  endfunction

  function automatic logic [7:0] vec_ref(input int idx);
    logic [7:0] t [8] = '{8'h08, 8'h00, 8'h08, 8'h00, 8'h0C, 8'h80, 8'h0C, 8'h00};
    return t[idx];
  endfunction

  always @(posedge clk) begin
    bit start, win_ok, vec_ok;
    if (!rst_n) begin
      m_st = 0; m_win = 0; m_drop = 0; m_rdq = 0;
      m_bb = 0; m_ex = 0; m_vec = 0; m_data = '0; m_req_addr = '0; pend = 0;
    end else begin
      start  = bus_rd && !m_rdq && (m_st == 0);
      win_ok = bus_addr >= 16'h8000 && bus_addr <= 16'h9FFF && !m_ex && !m_bb;
      vec_ok = bus_addr >= 16'hFFF8 && m_vec;
      case (m_st)
        0: if (start && win_ok) begin
             m_st = 1; m_win = 1; m_drop = 0;
             m_req_addr = {bank_sel, bus_addr[12:0]}; n_req++;
           end else if (start && vec_ok) begin
             m_st = 3; m_win = 0; m_data = vec_ref(int'(bus_addr[2:0]));
           end
        1: begin
             if (!bus_rd) m_drop = 1;
             if (req_ready) begin
               m_st = 2; pend = cur_lat; pend_addr = m_req_addr;
             end
           end
        2: begin
             if (fl_valid) begin
               if (m_drop || !bus_rd) m_st = 0;
               else begin m_st = 3; m_data = fl_data; end
             end
             if (!bus_rd) m_drop = 1;
           end
        default: if (!bus_rd) m_st = 0;
      endcase
      if (ctl_we) begin
        m_bb = ctl_wdata[2]; m_ex = ctl_wdata[1]; m_vec = ctl_wdata[0];
      end
      m_rdq = bus_rd;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit eo;
    eo = (m_st == 3) && !(m_win && (m_ex || m_bb));
    chk(cur_tag, "bus_oe", int'(bus_oe), int'(eo));
    chk(cur_tag, "bus_dout", int'(bus_dout), eo ? int'(m_data) : 0);
    chk(cur_tag, "req_valid", int'(req_valid), int'(m_st == 1));
    if (m_st == 1) chk("R1", "req_addr", int'(req_addr), int'(m_req_addr));
    chk("R5", "exrom_n", int'(exrom_n), int'(m_ex || m_bb));
    chk("R8", "io_sel", int'(io_sel), int'(bus_rd && bus_addr[15:8] == 8'hDE));
  endtask

  // one cycle: compare at the falling edge, then drive the sequencer side
  task automatic tick();
    @(negedge clk);
    if (rst_n) compare_all();
    req_ready = rdy_pat[0];
    rdy_pat = {rdy_pat[0], rdy_pat[7:1]};
    fl_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        fl_valid = 1'b1;
        fl_data  = flash_byte(pend_addr);
      end
    end
  endtask

  task automatic wr_ctl(input logic [2:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    tick();
    ctl_we = 1'b0;
  endtask

  task automatic rd_access(input logic [15:0] a, input logic [BANK_W-1:0] b);
    bus_addr = a; bank_sel = b; bus_rd = 1'b1;
    tick();
    for (int i = 0; i < 40; i++) begin
      tick();
      if (m_st == 3 || m_st == 0) break;
    end
    tick(); tick();
    bus_rd = 1'b0;
    tick(); tick();
  endtask

  task automatic rd_abort(input logic [15:0] a, input logic [BANK_W-1:0] b);
    bus_addr = a; bank_sel = b; bus_rd = 1'b1;
    tick(); tick();
    bus_rd = 1'b0;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (m_st == 0 && pend == 0) break;
    end
    tick();
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int nr;
    // R9 reset state
    repeat (3) tick();
    chk("R9", "bus_oe", int'(bus_oe), 0);
    chk("R9", "req_valid", int'(req_valid), 0);
    chk("R9", "exrom_n", int'(exrom_n), 0);
    chk("R9", "io_sel", int'(io_sel), 0);
    rst_n = 1'b1;
    tick();

    // R9 / R7: vector override reset value per parameter
    cur_tag = "R7";
    bus_addr = 16'hFFFD; bus_rd = 1'b1;
    tick(); tick();
    chk("R9", "vr bus_oe", int'(vr_oe), 1);
    chk("R9", "vr bus_dout", int'(vr_dout), 8'h80);
    chk("R7", "bus_oe vec off", int'(bus_oe), 0);
    bus_rd = 1'b0; tick(); tick();
    for (int i = 0; i < 8; i++) rd_access(16'hFFF8 + 16'(i), '0);

    // R6: vector table
    cur_tag = "R6";
    wr_ctl(3'b001);
    for (int i = 0; i < 8; i++) rd_access(16'hFFF8 + 16'(i), '0);

    // R1/R2: window reads with varied banks, latencies and back-pressure
    cur_tag = "R2";
    rdy_pat = 8'b1001_0010;
    for (int i = 0; i < 8; i++) begin
      nr = n_req;
      cur_lat = 1 + (i % 4);
      rd_access(16'h8000 + 16'(i * 16'h0411), BANK_W'(i * 263));
      chk("R1", "one request", n_req - nr, 1);
    end
    rdy_pat = 8'hFF;
    rd_access(16'h9FFF, '1);
    rd_access(16'h8000, '0);

    // R11: unmapped addresses, R8 io page
    cur_tag = "R11";
    nr = n_req;
    rd_access(16'hA000, 11'h12);
    rd_access(16'h7FFF, 11'h12);
    rd_access(16'hDE05, 11'h12);
    chk("R11", "no request", n_req - nr, 0);

    // R3: window released, vector and io still served
    wr_ctl(3'b011);
    cur_tag = "R3";
    nr = n_req;
    rd_access(16'h8123, 11'h44);
    chk("R3", "no request", n_req - nr, 0);
    cur_tag = "R6";
    rd_access(16'hFFFC, '0);
    rd_access(16'hDE10, '0);

    // R4: bit-bang blocks the window
    wr_ctl(3'b101);
    cur_tag = "R4";
    nr = n_req;
    rd_access(16'h9000, 11'h7);
    chk("R4", "no request", n_req - nr, 0);
    cur_tag = "R6";
    rd_access(16'hFFFE, '0);

    // R4: bit-bang entered while a window byte is driven
    wr_ctl(3'b000);
    cur_tag = "R4";
    cur_lat = 2;
    bus_addr = 16'h8ABC; bank_sel = 11'h155; bus_rd = 1'b1;
    for (int i = 0; i < 40; i++) begin
      tick();
      if (m_st == 3) break;
    end
    tick();
    chk("R4", "oe before bit-bang", int'(bus_oe), 1);
    ctl_we = 1'b1; ctl_wdata = 3'b100;
    tick();
    ctl_we = 1'b0;
    chk("R4", "oe after bit-bang", int'(bus_oe), 0);
    tick();
    bus_rd = 1'b0; tick(); tick();
    wr_ctl(3'b000);

    // R10: abandoned reads
    cur_tag = "R10";
    for (int i = 0; i < 3; i++) begin
      cur_lat = 3 + i;
      rdy_pat = (i == 1) ? 8'b0000_0001 : 8'hFF;
      rd_abort(16'h8800 + 16'(i), BANK_W'(i + 5));
    end
    rdy_pat = 8'hFF;

    // R11: read starting during an outstanding fetch is ignored
    cur_tag = "R11";
    cur_lat = 6;
    bus_addr = 16'h8100; bank_sel = 11'h3; bus_rd = 1'b1;
    tick(); tick(); tick();
    bus_rd = 1'b0; tick();
    nr = n_req;
    bus_addr = 16'h8200; bus_rd = 1'b1;
    for (int i = 0; i < 12; i++) tick();
    chk("R11", "no extra request", n_req - nr, 0);
    bus_rd = 1'b0;
    repeat (4) tick();

    cur_tag = "R2";
    cur_lat = 1;
    rd_access(16'h8FED, 11'h2AA);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule